// File: doc/BRIEF.md
# NOR Flash Identification Sequencer

This block reads the manufacturer and device codes of a parallel NOR flash used in 16-bit word mode. A host pulses a start input together with a 32-bit byte base address. The block then runs a fixed list of bus steps through a separate bus-cycle engine. First come three command writes that unlock the part and put it into identification mode. Next come two reads that return the two codes. Last comes one write that puts the flash back into normal array-read mode. Only after that write completes does the block raise done.

The engine side is a request/acknowledge interface. The block presents the operation, a 24-bit word address and 16-bit write data. It holds them steady until the engine acknowledges. Read data comes back on a 32-bit path, and the ID code is taken from its low 16 bits. If both 16-bit halves of a read come back as the identification command byte, the block sets an error flag. That pattern means the command cycles never reached the part at the right addresses, and the bus is echoing the last write.

Top module: `nor_id_seq`

## Requirements
- R1: After reset, req_o, busy_o, done_o, id_valid_o and err_o are 0, and both ID outputs are 0.
- R2: The word base is the host byte address shifted right by one, keeping its low 24 bits (bits 24:1). Every step address is this base plus the step offset, taken modulo 2^24.
- R3: The first three steps are writes (req_we_o=1), in this order: 0x00AA at offset 0x555, then 0x0055 at offset 0x2AA, then 0x0090 at offset 0x555.
- R4: The fourth step reads offset 0x000 and the fifth step reads offset 0x001 (req_we_o=0). The low 16 bits of their acknowledged data become mfr_id_o and dev_id_o respectively.
- R5: The sixth and last step writes 0x00F0 at offset 0x000.
- R6: While a request is unacknowledged, req_o stays 1 and address, data and operation stay stable. A step ends on the clock edge where ack_i is 1. The next step's request is presented from the cycle that follows.
- R7: done_o is a one-cycle pulse in the cycle after the final write is acknowledged. id_valid_o goes to 1 at the same time and stays 1 until the next accepted start. busy_o is 1 from the cycle after an accepted start until done_o.
- R8: start_i is accepted only when idle. A start while busy has no effect on the running sequence or on its addresses.
- R9: err_o is set when an acknowledged ID read returns 0x0090 in both 16-bit halves. It is not set if only one half matches. It is cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| base_addr_i | input | 32 | Host byte base address of the flash |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| id_valid_o | output | 1 | ID outputs hold the codes from the last run |
| err_o | output | 1 | Command-echo pattern seen on an ID read |
| mfr_id_o | output | 16 | Manufacturer code |
| dev_id_o | output | 16 | Device code |
| req_o | output | 1 | Bus-cycle request to the engine |
| req_we_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | 24 | Flash word address |
| req_wdata_o | output | 16 | Write data |
| ack_i | input | 1 | Engine acknowledge, completes the current step |
| rdata_i | input | 32 | Engine read data, valid with ack_i on reads |

## Verification
The assertions assume the engine raises ack_i only while req_o is high, and holds it for one cycle per step. They also assume rdata_i is meaningful only alongside an acknowledged read. The bench stands in for the engine so that it keeps to these rules. It acknowledges each request after 0 to 3 wait cycles and drops ack_i in the cycle after. It also pulses start_i in the middle of a run, so the idle-only acceptance rule is exercised without ever breaking the acknowledge contract.

// File: rtl/nor_id_pkg.sv
package nor_id_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNLOCK1, ST_UNLOCK2, ST_AUTOSEL, ST_RD_MFR, ST_RD_DEV, ST_EXIT
  } step_e;

  typedef struct packed {
    logic       we;
    logic [11:0] offset;
    logic [7:0]  data;
  } cmd_t;

  localparam logic [7:0] CMD_AUTOSEL = 8'h90;
endpackage

// File: rtl/nor_id_step_rom.sv
module nor_id_step_rom
  import nor_id_pkg::*;
(
  input  step_e step_i,
  output cmd_t  cmd_o
);
  always_comb begin
    unique case (step_i)
      ST_UNLOCK1: cmd_o = '{we: 1'b1, offset: 12'h555, data: 8'hAA};
      ST_UNLOCK2: cmd_o = '{we: 1'b1, offset: 12'h2AA, data: 8'h55};
      ST_AUTOSEL: cmd_o = '{we: 1'b1, offset: 12'h555, data: CMD_AUTOSEL};
      ST_RD_MFR:  cmd_o = '{we: 1'b0, offset: 12'h000, data: 8'h00};
      ST_RD_DEV:  cmd_o = '{we: 1'b0, offset: 12'h001, data: 8'h00};
      ST_EXIT:    cmd_o = '{we: 1'b1, offset: 12'h000, data: 8'hF0};
      default:    cmd_o = '{we: 1'b0, offset: 12'h000, data: 8'h00};
    endcase
  end
endmodule

// File: rtl/nor_id_addr_map.sv
module nor_id_addr_map #(
  parameter int HOST_AW  = 32,
  parameter int FLASH_AW = 24
) (
  input  logic [HOST_AW-1:0]  host_base_i,
  output logic [FLASH_AW-1:0] word_base_o
);
  // byte address to word address, upper host bits dropped
  assign word_base_o = host_base_i[FLASH_AW:1];

  logic unused_bits;
  assign unused_bits = ^{host_base_i[HOST_AW-1:FLASH_AW+1], host_base_i[0]};
endmodule

// File: rtl/nor_id_capture.sv
module nor_id_capture
  import nor_id_pkg::*;
#(
  parameter int FLASH_DW = 16,
  parameter int RD_W     = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                cap_mfr_i,
  input  logic                cap_dev_i,
  input  logic [RD_W-1:0]     rdata_i,
  output logic [FLASH_DW-1:0] mfr_o,
  output logic [FLASH_DW-1:0] dev_o,
  output logic                err_o
);
  localparam int LANES = RD_W / FLASH_DW;

  logic [LANES-1:0] lane_hit;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_hit[g] = rdata_i[g*FLASH_DW +: FLASH_DW] == FLASH_DW'(CMD_AUTOSEL);
  end

  logic echo_seen;
  assign echo_seen = (cap_mfr_i | cap_dev_i) & (&lane_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mfr_o <= '0;
      dev_o <= '0;
      err_o <= 1'b0;
    end else begin
      if (cap_mfr_i) mfr_o <= rdata_i[FLASH_DW-1:0];
      if (cap_dev_i) dev_o <= rdata_i[FLASH_DW-1:0];
      if (clr_i) err_o <= 1'b0;
      else if (echo_seen) err_o <= 1'b1;
    end
  end

  // R9
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(cap_mfr_i || cap_dev_i));
endmodule

// File: rtl/nor_id_seq.sv
module nor_id_seq
  import nor_id_pkg::*;
#(
  parameter int HOST_AW  = 32,
  parameter int FLASH_AW = 24,
  parameter int FLASH_DW = 16,
  parameter int RD_W     = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [HOST_AW-1:0]  base_addr_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                id_valid_o,
  output logic                err_o,
  output logic [FLASH_DW-1:0] mfr_id_o,
  output logic [FLASH_DW-1:0] dev_id_o,
  output logic                req_o,
  output logic                req_we_o,
  output logic [FLASH_AW-1:0] req_addr_o,
  output logic [FLASH_DW-1:0] req_wdata_o,
  input  logic                ack_i,
  input  logic [RD_W-1:0]     rdata_i
);
  step_e               state_q;
  logic [FLASH_AW-1:0] base_q, base_w;
  logic                done_q, valid_q;
  cmd_t                cmd;
  logic                accept;

  nor_id_addr_map #(.HOST_AW(HOST_AW), .FLASH_AW(FLASH_AW)) u_map (
    .host_base_i (base_addr_i),
    .word_base_o (base_w)
  );

  nor_id_step_rom u_rom (
    .step_i (state_q),
    .cmd_o  (cmd)
  );

  assign accept = start_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_UNLOCK1;
        base_q  <= base_w;
        valid_q <= 1'b0;
      end else if (state_q != ST_IDLE && ack_i) begin
        if (state_q == ST_EXIT) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          valid_q <= 1'b1;
        end else begin
          state_q <= step_e'(state_q + 3'd1);
        end
      end
    end
  end

  nor_id_capture #(.FLASH_DW(FLASH_DW), .RD_W(RD_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .cap_mfr_i (state_q == ST_RD_MFR && ack_i),
    .cap_dev_i (state_q == ST_RD_DEV && ack_i),
    .rdata_i   (rdata_i),
    .mfr_o     (mfr_id_o),
    .dev_o     (dev_id_o),
    .err_o     (err_o)
  );

  assign req_o       = state_q != ST_IDLE;
  assign busy_o      = req_o;
  assign req_we_o    = cmd.we;
  assign req_addr_o  = base_q + FLASH_AW'(cmd.offset);
  assign req_wdata_o = FLASH_DW'(cmd.data);
  assign done_o      = done_q;
  assign id_valid_o  = valid_q;

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(req_addr_o) && $stable(req_wdata_o)
                        && $stable(req_we_o));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && id_valid_o);
  // R8
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !ack_i |=> busy_o && $stable(req_addr_o));
endmodule

// File: tb/nor_id_seq_bench.sv
module nor_id_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base = '0;
  logic        busy, done, valid, err, req, we, ack = 1'b0;
  logic [15:0] mfr, dev, wdata;
  logic [23:0] addr;
  logic [31:0] rdata = '0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  nor_id_seq u_nor_id_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base),
    .busy_o(busy), .done_o(done), .id_valid_o(valid), .err_o(err),
    .mfr_id_o(mfr), .dev_id_o(dev), .req_o(req), .req_we_o(we),
    .req_addr_o(addr), .req_wdata_o(wdata), .ack_i(ack), .rdata_i(rdata)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] b, input int lat, input int mode);
    logic [11:0] offs [6] = '{12'h555, 12'h2AA, 12'h555, 12'h000, 12'h001, 12'h000};
    logic [15:0] dats [6] = '{16'h00AA, 16'h0055, 16'h0090, 16'h0000, 16'h0000, 16'h00F0};
    logic        wes  [6] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    logic [23:0] wb;
    logic [15:0] em, ed;
    logic [31:0] rd;
    wb = b[24:1];
    em = 16'h1000 ^ b[15:0];
    ed = 16'h2200 + 16'(lat);
    @(negedge clk);
    base = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; base = ~b;
    check(busy && !valid, "R7 busy after start", {30'd0, busy, valid}, 32'h2);
    for (int k = 0; k < 6; k++) begin
      logic [23:0] ea;
      ea = wb + 24'(offs[k]);
      check(req == 1'b1, "R6 req presented", {31'd0, req}, 32'd1);
      check(addr == ea, "R2 step address", {8'd0, addr}, {8'd0, ea});
      check(we == wes[k], k < 3 ? "R3 op" : (k < 5 ? "R4 op" : "R5 op"),
            {31'd0, we}, {31'd0, wes[k]});
      if (wes[k])
        check(wdata == dats[k], k < 3 ? "R3 data" : "R5 data",
              {16'd0, wdata}, {16'd0, dats[k]});
      for (int w = 0; w < lat; w++) begin
        if (k == 2 && w == 0) begin base = 32'h0ABC_DEF0; start = 1'b1; end
        @(negedge clk);
        start = 1'b0;
        check(req && addr == ea, "R6/R8 held", {8'd0, addr}, {8'd0, ea});
      end
      if (k == 2 && lat == 0) start = 1'b1;
      rd = {16'hBEEF, (k == 3) ? em : ed};
      if (k >= 3 && k <= 4 && mode == 1) rd = 32'h0090_0090;
      if (k == 4 && mode == 2) rd = 32'h1234_0090;
      if (k == 4 && mode == 2) ed = 16'h0090;
      if (mode == 1) begin em = 16'h0090; ed = 16'h0090; end
      rdata = rd; ack = 1'b1;
      @(negedge clk);
      ack = 1'b0; start = 1'b0; rdata = '0;
    end
    check(done && valid && !busy && !req, "R7 done pulse",
          {28'd0, done, valid, busy, req}, 32'hC);
    check(mfr == em, "R4 mfr id", {16'd0, mfr}, {16'd0, em});
    check(dev == ed, "R4 dev id", {16'd0, dev}, {16'd0, ed});
    check(err == (mode == 1), "R9 error flag", {31'd0, err}, {31'd0, mode == 1});
    @(negedge clk);
    check(!done && valid, "R7 done single", {30'd0, done, valid}, 32'h1);
  endtask

  initial begin
    logic [31:0] bases [6] = '{32'h0000_0000, 32'h4000_0000, 32'h0123_4567,
                               32'hFFFF_FFFE, 32'h01FF_FFFF, 32'h8000_0AAA};
    #1;
    check(!req && !busy && !done && !valid && !err && mfr == 0 && dev == 0,
          "R1 reset state", {27'd0, req, busy, done, valid, err}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++)
      for (int l = 0; l < 4; l++)
        for (int m = 0; m < 3; m++)
          run(bases[i], l, m);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule